// File: doc/BRIEF.md
# Power Mode Sequencer

This controller moves a lighting management chip through its five operating modes: reset, standby, internal startup, boost soft-start and normal. It watches an active-low external reset, an internal power-on-reset flag, a standby-release control bit, a boost-enable control bit and a thermal-shutdown flag. From these it drives the enables for the reference and oscillator and for the boost converter. It also produces a soft-start (PFM) flag, a blanking signal for the RGB outputs and a register-clear strobe.

Both timed phases last 10 ms. A single shared cycle counter times them. Its terminal count is `CLK_HZ/100`, and it restarts on every mode change. While thermal shutdown is flagged, the chip holds in internal startup with its timer at zero. A thermal event during boost soft-start or normal operation sends the chip back to startup. A rising boost-enable bit during normal operation re-runs the boost soft-start.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_ni` is low, `mode_o` is 0 (RESET) and `reg_clear_o` is 1. A `por_i` high at a clock edge gives `mode_o`=0 after that edge, and the mode stays 0 while `por_i` stays high. Mode codes: RESET=0, STANDBY=1, STARTUP=2, BOOST_STARTUP=3, NORMAL=4.
- R2: From RESET with `por_i` low, the next edge enters STANDBY. In STANDBY, `ref_osc_en_o`, `boost_on_o` and `pfm_o` are 0 and `rgb_off_o` is 1.
- R3: In STANDBY, `stby_rel_i` high moves the block to STARTUP at the next edge. `ref_osc_en_o` is 1 in STARTUP when thermal shutdown is clear.
- R4: STARTUP lasts exactly `CLK_HZ/100` cycles. It then goes to BOOST_STARTUP if `boost_en_i` is high, otherwise to NORMAL.
- R5: While `therm_sd_i` is high, STARTUP is held and `ref_osc_en_o` is 0. The full `CLK_HZ/100` count restarts once the flag clears.
- R6: `therm_sd_i` high in BOOST_STARTUP or NORMAL returns the block to STARTUP at the next edge.
- R7: BOOST_STARTUP lasts exactly `CLK_HZ/100` cycles and then goes to NORMAL. Throughout it, `pfm_o`=1, `boost_on_o`=1 and `rgb_off_o`=1.
- R8: In NORMAL, a low-to-high change of `boost_en_i` enters BOOST_STARTUP at the next edge. The boost converter stays off in the cycle of the change. A level that stays high does not retrigger.
- R9: `stby_rel_i` low in any non-reset mode gives STANDBY at the next edge.
- R10: In NORMAL, `rgb_off_o`=0, `pfm_o`=0, `ref_osc_en_o`=1, and `boost_on_o` follows a boost-enable level that is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External active-low asynchronous reset |
| por_i | input | 1 | Internal power-on-reset, active high |
| stby_rel_i | input | 1 | Standby-release control bit |
| boost_en_i | input | 1 | Boost-enable control bit |
| therm_sd_i | input | 1 | Thermal-shutdown flag |
| mode_o | output | 3 | Current mode code |
| reg_clear_o | output | 1 | Return control registers to defaults |
| ref_osc_en_o | output | 1 | Reference and oscillator enable |
| boost_on_o | output | 1 | Boost converter enable |
| pfm_o | output | 1 | Boost soft-start (PFM) flag |
| rgb_off_o | output | 1 | Force all RGB outputs off |

## Verification
The assertions check the following transitions on every cycle:
- the power-on-reset override;
- the drop to standby;
- the thermal return to startup and the thermal hold inside it;
- the boost-enable edge in normal;
- the branch taken at the end of startup;
- the bound on the delay counter;
- the coupling of soft-start to blanking.

Only the bench scenarios can show the exact length of each 10 ms phase. The same holds for the restart of the count after a thermal hold, the missing retrigger on a held boost-enable level, and the output values in each mode.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_RESET   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_STARTUP = 3'd2,
    MODE_BOOST   = 3'd3,
    MODE_NORMAL  = 3'd4
  } mode_e;
endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
  parameter int unsigned TERM = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear_i || !run_i)   cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R4/R7: delay counter never passes terminal count
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  por_i,
  input  logic  stby_rel_i,
  input  logic  boost_en_i,
  input  logic  therm_sd_i,
  input  logic  done_i,
  output mode_e state_o,
  output logic  boost_en_q_o,
  output logic  run_o,
  output logic  clear_o
);
  mode_e state_q, state_d;
  logic  boost_q;
  logic  boost_rise;

  assign boost_rise = boost_en_i && !boost_q;

  always_comb begin
    state_d = state_q;
    if (por_i) begin
      state_d = MODE_RESET;
    end else begin
      case (state_q)
        MODE_RESET:   state_d = MODE_STANDBY;
        MODE_STANDBY: if (stby_rel_i) state_d = MODE_STARTUP;
        MODE_STARTUP: begin
          if (!stby_rel_i)  state_d = MODE_STANDBY;
          else if (done_i)  state_d = boost_en_i ? MODE_BOOST : MODE_NORMAL;
        end
        MODE_BOOST: begin
          if (!stby_rel_i)     state_d = MODE_STANDBY;
          else if (therm_sd_i) state_d = MODE_STARTUP;
          else if (done_i)     state_d = MODE_NORMAL;
        end
        MODE_NORMAL: begin
          if (!stby_rel_i)     state_d = MODE_STANDBY;
          else if (therm_sd_i) state_d = MODE_STARTUP;
          else if (boost_rise) state_d = MODE_BOOST;
        end
        default: state_d = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_RESET;
      boost_q <= 1'b0;
    end else begin
      state_q <= state_d;
      boost_q <= boost_en_i;
    end
  end

  assign state_o      = state_q;
  assign boost_en_q_o = boost_q;
  assign run_o   = ((state_q == MODE_STARTUP) || (state_q == MODE_BOOST)) && !therm_sd_i;
  assign clear_o = (state_d != state_q);

  a_r1_por_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (state_q == MODE_RESET));

  a_r9_standby_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !stby_rel_i && state_q != MODE_RESET) |=> (state_q == MODE_STANDBY));

  a_r6_therm_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && stby_rel_i && therm_sd_i &&
     (state_q == MODE_BOOST || state_q == MODE_NORMAL)) |=> (state_q == MODE_STARTUP));

  a_r5_therm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && stby_rel_i && therm_sd_i && state_q == MODE_STARTUP) |=> (state_q == MODE_STARTUP));

  a_r8_boost_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && stby_rel_i && !therm_sd_i && state_q == MODE_NORMAL && boost_rise)
      |=> (state_q == MODE_BOOST));

  a_r4_startup_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && stby_rel_i && done_i && state_q == MODE_STARTUP)
      |=> (state_q == (boost_en_q_o ? MODE_BOOST : MODE_NORMAL)));
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      state_i,
  input  logic       boost_en_i,
  input  logic       boost_en_q_i,
  input  logic       therm_sd_i,
  output logic [2:0] mode_o,
  output logic       reg_clear_o,
  output logic       ref_osc_en_o,
  output logic       boost_on_o,
  output logic       pfm_o,
  output logic       rgb_off_o
);
  logic powered;

  assign powered      = (state_i == MODE_STARTUP) || (state_i == MODE_BOOST) ||
                        (state_i == MODE_NORMAL);
  assign mode_o       = state_i;
  assign reg_clear_o  = (state_i == MODE_RESET);
  assign ref_osc_en_o = powered && !therm_sd_i;
  assign pfm_o        = (state_i == MODE_BOOST);
  // in normal, wait one cycle on a fresh enable so soft-start runs first
  assign boost_on_o   = pfm_o || ((state_i == MODE_NORMAL) && boost_en_i && boost_en_q_i);
  assign rgb_off_o    = (state_i != MODE_NORMAL);

  a_r7_pfm_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfm_o |-> (rgb_off_o && boost_on_o));

  a_r2_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_clear_o |-> (!ref_osc_en_o && !boost_on_o && rgb_off_o));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       stby_rel_i,
  input  logic       boost_en_i,
  input  logic       therm_sd_i,
  output logic [2:0] mode_o,
  output logic       reg_clear_o,
  output logic       ref_osc_en_o,
  output logic       boost_on_o,
  output logic       pfm_o,
  output logic       rgb_off_o
);
  localparam int unsigned TERM = (CLK_HZ / 100 > 1) ? CLK_HZ / 100 : 2;

  mode_e state;
  logic  boost_q, run, clear, done;

  pwr_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_i        (por_i),
    .stby_rel_i   (stby_rel_i),
    .boost_en_i   (boost_en_i),
    .therm_sd_i   (therm_sd_i),
    .done_i       (done),
    .state_o      (state),
    .boost_en_q_o (boost_q),
    .run_o        (run),
    .clear_o      (clear)
  );

  pwr_delay_timer #(.TERM(TERM)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .run_i   (run),
    .done_o  (done)
  );

  pwr_mode_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .boost_en_i   (boost_en_i),
    .boost_en_q_i (boost_q),
    .therm_sd_i   (therm_sd_i),
    .mode_o       (mode_o),
    .reg_clear_o  (reg_clear_o),
    .ref_osc_en_o (ref_osc_en_o),
    .boost_on_o   (boost_on_o),
    .pfm_o        (pfm_o),
    .rgb_off_o    (rgb_off_o)
  );
endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int unsigned CLK_HZ = 2000;
  localparam int TERM = CLK_HZ / 100;

  logic clk = 1'b0;
  logic rst_ni, por, stby, boost, therm;
  logic [2:0] mode;
  logic reg_clear, ref_osc, boost_on, pfm, rgb_off;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por), .stby_rel_i(stby),
    .boost_en_i(boost), .therm_sd_i(therm), .mode_o(mode),
    .reg_clear_o(reg_clear), .ref_osc_en_o(ref_osc), .boost_on_o(boost_on),
    .pfm_o(pfm), .rgb_off_o(rgb_off)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; por = 1'b0; stby = 1'b0; boost = 1'b0; therm = 1'b0;
    step(3);
    chk("R1 mode in reset", mode, 0);
    chk("R1 reg clear", reg_clear, 1);
    rst_ni = 1'b1;
    step(1);
    chk("R2 standby after reset", mode, 1);
    chk("R2 ref off", ref_osc, 0);
    chk("R2 boost off", boost_on, 0);
    chk("R2 rgb blanked", rgb_off, 1);
    chk("R2 reg clear low", reg_clear, 0);
  endtask

  task automatic t_startup_normal;
    stby = 1'b1;
    step(1);
    chk("R3 startup entered", mode, 2);
    chk("R3 ref on", ref_osc, 1);
    step(TERM - 1);
    chk("R4 still startup", mode, 2);
    step(1);
    chk("R4 normal after delay", mode, 4);
    chk("R10 rgb active", rgb_off, 0);
    chk("R10 pfm low", pfm, 0);
    chk("R10 ref on", ref_osc, 1);
    chk("R10 boost off", boost_on, 0);
  endtask

  task automatic t_boost_from_normal;
    boost = 1'b1;
    #0.5;
    chk("R8 boost off in edge cycle", boost_on, 0);
    step(1);
    chk("R8 boost startup entered", mode, 3);
    chk("R7 pfm", pfm, 1);
    chk("R7 boost on", boost_on, 1);
    chk("R7 rgb blanked", rgb_off, 1);
    step(TERM - 1);
    chk("R7 still boost startup", mode, 3);
    step(1);
    chk("R7 normal after soft start", mode, 4);
    chk("R10 boost follows enable", boost_on, 1);
    chk("R10 pfm off", pfm, 0);
    step(5);
    chk("R8 no retrigger", mode, 4);
  endtask

  task automatic t_therm;
    therm = 1'b1;
    step(1);
    chk("R6 normal to startup", mode, 2);
    chk("R5 ref off in thermal", ref_osc, 0);
    step(30);
    chk("R5 held in startup", mode, 2);
    therm = 1'b0;
    step(TERM - 1);
    chk("R5 count restarted", mode, 2);
    step(1);
    chk("R4 boost branch", mode, 3);
    step(5);
    therm = 1'b1;
    step(1);
    chk("R6 boost to startup", mode, 2);
    therm = 1'b0;
  endtask

  task automatic t_standby;
    stby = 1'b0;
    step(1);
    chk("R9 startup to standby", mode, 1);
    chk("R2 ref off in standby", ref_osc, 0);
    boost = 1'b0;
    stby = 1'b1;
    step(TERM + 1);
    chk("R4 normal without boost", mode, 4);
    stby = 1'b0;
    step(1);
    chk("R9 normal to standby", mode, 1);
  endtask

  task automatic t_por;
    stby = 1'b1;
    step(2);
    por = 1'b1;
    step(1);
    chk("R1 por gives reset", mode, 0);
    step(3);
    chk("R1 por held", mode, 0);
    chk("R1 por reg clear", reg_clear, 1);
    por = 1'b0;
    step(1);
    chk("R2 standby after por", mode, 1);
  endtask

  initial begin
    t_reset();
    t_startup_normal();
    t_boost_from_normal();
    t_therm();
    t_standby();
    t_por();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule